// File: doc/BRIEF.md
# Transmit Session Sequencer

This block sequences one transmit session of a serially configured RF transmitter. A decoder upstream turns a serial frame into a single-cycle transmit command with five option flags. The sequencer then turns on the synthesizer, waits for the serial clock to stay low long enough for the loop to settle, and turns on the power amplifier at the next serial-clock rising edge. While the session runs, the transmit data bit follows the serial data line.

The command picks one of two parameter banks (modulation type, amplifier sub-block mask, power code), bypasses or enables the line encoder, and selects one of four frequency register sets. When the command asks for it, a falling enable line does not stop the session. The data level seen at that edge is frozen and sent on until a long timeout ends the session, or until a new command restarts the sequence from settling.

The enable, serial clock and serial data pins each pass through a two-flop synchronizer before the block uses them. Configuration comes from three 8-bit register values that the block reads live.

Top module: `txseq_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it drops with no command, `pll_en`, `pa_en`, `tx_bit`, `enc_en`, `enc_mode`, `mod_fsk`, `pa_mask`, `pa_pwr` and `freq_set` are all zero.
- R2: One cycle after a `cmd_valid` pulse, `pll_en` is 1 and `pa_en` is 0. `pa_en` is never 1 while `pll_en` is 0.
- R3: `pa_en` rises only on a synchronized serial-clock rising edge seen after the clock has been low for at least SETTLE_CYC consecutive cycles since the command. An earlier rising edge is ignored and restarts the low-time count from zero.
- R4: While the amplifier is on and not in hold, `tx_bit` follows the synchronized serial data level, whatever the serial-clock level.
- R5: With the hold flag at 0, a synchronized falling edge on `en_pin` during transmission turns `pa_en`, `pll_en` and `tx_bit` off.
- R6: With the hold flag at 1, a synchronized falling edge on `en_pin` during transmission keeps `pa_en` at 1 and freezes `tx_bit` at the data level sampled at that edge. Later data changes have no effect.
- R7: In hold, after HOLD_CYC cycles without a new command, `pa_en` and `pll_en` both drop to 0.
- R8: A command that arrives during hold clears the hold timer, drops `pa_en` on the next cycle, keeps `pll_en` at 1, and restarts settling.
- R9: Bank flag 0 selects `mod_fsk` = `cfg_txc`[5], `pa_mask` = `cfg_pasel`[4:2] and `pa_pwr` = `cfg_pout`[3:0]. Bank flag 1 selects `cfg_txc`[6], `cfg_pasel`[7:5] and `cfg_pout`[7:4]. `mod_fsk` = 1 means FSK and 0 means ASK.
- R10: During a session, `enc_en` equals the encoder flag. `enc_mode` is `cfg_txc`[2:0] when the encoder flag is 1 and 0 otherwise.
- R11: During a session, `freq_set` equals the 2-bit frequency flag in binary order: 0 selects set A, 1 set B, 2 set C and 3 set D.
- R12: A falling edge on `en_pin` while settling has no effect: `pll_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle pulse for a decoded transmit command |
| cmd_hold | input | 1 | Keep transmitting after enable falls |
| cmd_enc | input | 1 | Use the line encoder |
| cmd_bank | input | 1 | Parameter bank select |
| cmd_freq | input | 2 | Frequency register set select |
| en_pin | input | 1 | Asynchronous enable line |
| sclk_pin | input | 1 | Asynchronous serial clock line |
| sdio_pin | input | 1 | Asynchronous serial data line |
| cfg_txc | input | 8 | Transmit config: modulation bits [6:5], encoder mode [2:0] |
| cfg_pasel | input | 8 | Amplifier sub-block masks, [7:5] and [4:2] |
| cfg_pout | input | 8 | Power codes, [7:4] and [3:0] |
| pll_en | output | 1 | Synthesizer enable |
| pa_en | output | 1 | Power amplifier enable |
| tx_bit | output | 1 | Data bit to the modulator |
| mod_fsk | output | 1 | 1 = FSK, 0 = ASK |
| pa_mask | output | 3 | Amplifier sub-block activation mask |
| pa_pwr | output | 4 | Output power code |
| freq_set | output | 2 | Frequency set select, 0..3 = A..D |
| enc_en | output | 1 | Encoder enable |
| enc_mode | output | 3 | Encoder mode |

## Verification
The assertions assume that `cmd_valid` is a single-cycle pulse and that the pins change slowly compared with the system clock, so every pin edge survives synchronization as exactly one detected edge. The bench drives the pins only at falling clock edges and holds each level for several cycles, and it issues commands as isolated one-cycle pulses. It uses small settle and hold limits, so each window boundary lies a known number of cycles away from the samples taken around it.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic       hold;
        logic       enc;
        logic       bank;
        logic [1:0] freq;
    } tx_cmd_t;

    typedef struct packed {
        logic       fsk;
        logic [2:0] mask;
        logic [3:0] pwr;
    } bank_cfg_t;

    localparam int MOD_LSB   = 5;
    localparam int MASK_LSB  = 2;
    localparam int MASK_W    = 3;
    localparam int PWR_W     = 4;
    localparam int ENCMODE_W = 3;

    function automatic bank_cfg_t pick_bank(
        input logic       bank,
        input logic [7:0] txc,
        input logic [7:0] pasel,
        input logic [7:0] pout
    );
        bank_cfg_t r;
        r.fsk  = bank ? txc[MOD_LSB + 1] : txc[MOD_LSB];
        r.mask = bank ? pasel[MASK_LSB + MASK_W +: MASK_W] : pasel[MASK_LSB +: MASK_W];
        r.pwr  = bank ? pout[PWR_W +: PWR_W] : pout[0 +: PWR_W];
        return r;
    endfunction

endpackage

// File: rtl/txseq_sync.sv
module txseq_sync #(
    parameter int LANES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] lvl,
    output logic [LANES-1:0] rise,
    output logic [LANES-1:0] fall
);
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            logic ff1, ff2, prev;
            always_ff @(posedge clk) begin
                if (rst) begin
                    ff1  <= 1'b0;
                    ff2  <= 1'b0;
                    prev <= 1'b0;
                end else begin
                    ff1  <= din[i];
                    ff2  <= ff1;
                    prev <= ff2;
                end
            end
            assign lvl[i]  = ff2;
            assign rise[i] = ff2 & ~prev;
            assign fall[i] = ~ff2 & prev;
        end
    endgenerate
endmodule

// File: rtl/txseq_fsm.sv
module txseq_fsm
    import txseq_pkg::*;
#(
    parameter int SETTLE_CYC = 1300,
    parameter int HOLD_CYC   = 65536
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cmd_valid,
    input  tx_cmd_t cmd_in,
    input  logic    en_fall,
    input  logic    sclk_lvl,
    input  logic    sclk_rise,
    input  logic    sdio_lvl,
    output logic    pll_en,
    output logic    pa_en,
    output logic    tx_bit,
    output logic    session,
    output tx_cmd_t cmd_q
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [SW-1:0] SETTLE_DONE = SW'(SETTLE_CYC);
    localparam logic [HW-1:0] HOLD_LAST   = HW'(HOLD_CYC - 1);

    seq_state_e    st_q;
    logic [SW-1:0] settle_cnt;
    logic [HW-1:0] hold_tmr;
    logic          held_bit;
    logic          settle_done;

    assign settle_done = (settle_cnt >= SETTLE_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            settle_cnt <= '0;
            hold_tmr   <= '0;
            held_bit   <= 1'b0;
            cmd_q      <= '0;
        end else if (cmd_valid) begin
            st_q       <= ST_SETTLE;
            settle_cnt <= '0;
            hold_tmr   <= '0;
            cmd_q      <= cmd_in;
        end else begin
            case (st_q)
                ST_SETTLE: begin
                    if (!sclk_lvl) begin
                        if (!settle_done) settle_cnt <= settle_cnt + 1'b1;
                    end else if (sclk_rise && settle_done) begin
                        st_q <= ST_ACTIVE;
                    end else begin
                        settle_cnt <= '0;
                    end
                end
                ST_ACTIVE: begin
                    if (en_fall) begin
                        if (cmd_q.hold) begin
                            st_q     <= ST_HOLD;
                            held_bit <= sdio_lvl;
                            hold_tmr <= '0;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                ST_HOLD: begin
                    if (hold_tmr == HOLD_LAST) begin
                        st_q <= ST_IDLE;
                    end else begin
                        hold_tmr <= hold_tmr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        pll_en  = (st_q != ST_IDLE);
        session = (st_q != ST_IDLE);
        pa_en   = (st_q == ST_ACTIVE) || (st_q == ST_HOLD);
        case (st_q)
            ST_ACTIVE: tx_bit = sdio_lvl;
            ST_HOLD:   tx_bit = held_bit;
            default:   tx_bit = 1'b0;
        endcase
    end

    // R2: amplifier on only with synthesizer on
    a_r2_pa_needs_pll: assert property (@(posedge clk) disable iff (rst)
        pa_en |-> pll_en);

    // R3: early rising edge ignored, low-time count restarted
    a_r3_early_rise: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SETTLE && sclk_rise && !settle_done && !cmd_valid)
        |=> (st_q == ST_SETTLE && settle_cnt == '0));

    // R5: enable fall without hold ends the session
    a_r5_stop_on_en: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ACTIVE && en_fall && !cmd_q.hold && !cmd_valid)
        |=> (!pa_en && !pll_en));

    // R6: frozen data bit stays put during hold
    a_r6_hold_steady: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD && hold_tmr != HOLD_LAST && !cmd_valid)
        |=> (tx_bit == $past(tx_bit)));

    // R7: hold timeout shuts both enables
    a_r7_timeout_off: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD && hold_tmr == HOLD_LAST && !cmd_valid)
        |=> (!pa_en && !pll_en));

    // R8: command in hold drops amplifier, restarts settling
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD && cmd_valid) |=> (!pa_en && pll_en && hold_tmr == '0));
endmodule

// File: rtl/txseq_bank_sel.sv
module txseq_bank_sel
    import txseq_pkg::*;
(
    input  tx_cmd_t                cmd_q,
    input  logic                   session,
    input  logic [7:0]             cfg_txc,
    input  logic [7:0]             cfg_pasel,
    input  logic [7:0]             cfg_pout,
    output logic                   mod_fsk,
    output logic [MASK_W-1:0]      pa_mask,
    output logic [PWR_W-1:0]       pa_pwr,
    output logic [1:0]             freq_set,
    output logic                   enc_en,
    output logic [ENCMODE_W-1:0]   enc_mode
);
    bank_cfg_t sel;

    always_comb begin
        sel = pick_bank(cmd_q.bank, cfg_txc, cfg_pasel, cfg_pout);
        if (!session) sel = '0;
        mod_fsk  = sel.fsk;
        pa_mask  = sel.mask;
        pa_pwr   = sel.pwr;
        freq_set = session ? cmd_q.freq : 2'd0;
        enc_en   = session & cmd_q.enc;
        enc_mode = enc_en ? cfg_txc[ENCMODE_W-1:0] : '0;
    end

    // R10: mode only presented with encoder enabled
    always_comb begin
        a_r10_mode_gated: assert (enc_en || enc_mode == '0);
    end
endmodule

// File: rtl/txseq_top.sv
module txseq_top
    import txseq_pkg::*;
#(
    parameter int SETTLE_CYC = 1300,
    parameter int HOLD_CYC   = 65536
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic       cmd_hold,
    input  logic       cmd_enc,
    input  logic       cmd_bank,
    input  logic [1:0] cmd_freq,
    input  logic       en_pin,
    input  logic       sclk_pin,
    input  logic       sdio_pin,
    input  logic [7:0] cfg_txc,
    input  logic [7:0] cfg_pasel,
    input  logic [7:0] cfg_pout,
    output logic       pll_en,
    output logic       pa_en,
    output logic       tx_bit,
    output logic       mod_fsk,
    output logic [2:0] pa_mask,
    output logic [3:0] pa_pwr,
    output logic [1:0] freq_set,
    output logic       enc_en,
    output logic [2:0] enc_mode
);
    localparam int LN_EN   = 0;
    localparam int LN_SCLK = 1;
    localparam int LN_SDIO = 2;

    logic [2:0] pin_lvl, pin_rise, pin_fall;
    tx_cmd_t    cmd_in, cmd_q;
    logic       session;

    assign cmd_in = '{hold: cmd_hold, enc: cmd_enc, bank: cmd_bank, freq: cmd_freq};

    txseq_sync #(.LANES(3)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({sdio_pin, sclk_pin, en_pin}),
        .lvl  (pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    txseq_fsm #(.SETTLE_CYC(SETTLE_CYC), .HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_in    (cmd_in),
        .en_fall   (pin_fall[LN_EN]),
        .sclk_lvl  (pin_lvl[LN_SCLK]),
        .sclk_rise (pin_rise[LN_SCLK]),
        .sdio_lvl  (pin_lvl[LN_SDIO]),
        .pll_en    (pll_en),
        .pa_en     (pa_en),
        .tx_bit    (tx_bit),
        .session   (session),
        .cmd_q     (cmd_q)
    );

    txseq_bank_sel u_bank (
        .cmd_q     (cmd_q),
        .session   (session),
        .cfg_txc   (cfg_txc),
        .cfg_pasel (cfg_pasel),
        .cfg_pout  (cfg_pout),
        .mod_fsk   (mod_fsk),
        .pa_mask   (pa_mask),
        .pa_pwr    (pa_pwr),
        .freq_set  (freq_set),
        .enc_en    (enc_en),
        .enc_mode  (enc_mode)
    );

    logic unused_pins;
    assign unused_pins = ^{pin_rise[LN_EN], pin_rise[LN_SDIO], pin_fall[LN_SCLK],
                           pin_fall[LN_SDIO], pin_lvl[LN_EN]};
endmodule

// File: tb/txseq_top_bench.sv
module txseq_top_bench;
    localparam int SETTLE = 20;
    localparam int HOLD   = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0, cmd_hold = 1'b0, cmd_enc = 1'b0, cmd_bank = 1'b0;
    logic [1:0] cmd_freq = 2'd0;
    logic en_pin = 1'b0, sclk_pin = 1'b0, sdio_pin = 1'b0;
    logic [7:0] cfg_txc = 8'd0, cfg_pasel = 8'd0, cfg_pout = 8'd0;
    logic pll_en, pa_en, tx_bit, mod_fsk, enc_en;
    logic [2:0] pa_mask, enc_mode;
    logic [3:0] pa_pwr;
    logic [1:0] freq_set;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    txseq_top #(.SETTLE_CYC(SETTLE), .HOLD_CYC(HOLD)) u_txseq_top (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_hold(cmd_hold),
        .cmd_enc(cmd_enc), .cmd_bank(cmd_bank), .cmd_freq(cmd_freq),
        .en_pin(en_pin), .sclk_pin(sclk_pin), .sdio_pin(sdio_pin),
        .cfg_txc(cfg_txc), .cfg_pasel(cfg_pasel), .cfg_pout(cfg_pout),
        .pll_en(pll_en), .pa_en(pa_en), .tx_bit(tx_bit), .mod_fsk(mod_fsk),
        .pa_mask(pa_mask), .pa_pwr(pa_pwr), .freq_set(freq_set),
        .enc_en(enc_en), .enc_mode(enc_mode)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic h, input logic c, input logic d, input logic [1:0] f);
        cmd_hold = h; cmd_enc = c; cmd_bank = d; cmd_freq = f;
        cmd_valid = 1'b1;
        tick(1);
        cmd_valid = 1'b0;
    endtask

    task automatic start_tx();
        sclk_pin = 1'b0;
        tick(SETTLE + 10);
        sclk_pin = 1'b1;
        tick(5);
    endtask

    initial begin
        tick(4);
        // R1: reset state
        chk("R1 reset outputs", {pll_en, pa_en, tx_bit, mod_fsk, pa_mask, pa_pwr,
                                 freq_set, enc_en, enc_mode}, 0);
        rst = 1'b0;
        tick(1);
        chk("R1 idle after reset", {pll_en, pa_en, enc_en, freq_set}, 0);

        // R9 R10 R11 R2: sweep over bank, encoder and frequency flags
        for (int i = 0; i < 16; i++) begin
            logic d, c;
            logic [1:0] f;
            d = i[3]; c = i[2]; f = i[1:0];
            cfg_txc   = 8'((i * 37 + 5) & 255);
            cfg_pasel = 8'((i * 53 + 11) & 255);
            cfg_pout  = 8'((i * 29 + 3) & 255);
            issue(1'b0, c, d, f);
            chk("R2 pll on after command", {31'd0, pll_en}, 1);
            chk("R2 pa off while settling", {31'd0, pa_en}, 0);
            chk("R9 modulation bit", {31'd0, mod_fsk}, (cfg_txc >> (5 + d)) & 1);
            chk("R9 pa mask", {29'd0, pa_mask}, (cfg_pasel >> (2 + 3 * d)) & 7);
            chk("R9 power code", {28'd0, pa_pwr}, (cfg_pout >> (4 * d)) & 15);
            chk("R10 encoder enable", {31'd0, enc_en}, c);
            chk("R10 encoder mode", {29'd0, enc_mode}, c ? (cfg_txc & 7) : 0);
            chk("R11 frequency set", {30'd0, freq_set}, f);
        end
        rst = 1'b1; tick(2); rst = 1'b0; tick(1);

        // R3 R12: settling window
        en_pin = 1'b1; sclk_pin = 1'b0;
        issue(1'b0, 1'b0, 1'b0, 2'd2);
        tick(3);
        en_pin = 1'b0; tick(5);
        chk("R12 enable fall while settling", {31'd0, pll_en}, 1);
        en_pin = 1'b1;
        tick(2);
        sclk_pin = 1'b1; tick(6);
        chk("R3 early rise ignored", {31'd0, pa_en}, 0);
        sclk_pin = 1'b0; tick(12);
        sclk_pin = 1'b1; tick(6);
        chk("R3 count restarted", {31'd0, pa_en}, 0);
        start_tx();
        chk("R3 rise after settle starts pa", {31'd0, pa_en}, 1);

        // R4: data follows sdio regardless of sclk
        sdio_pin = 1'b1; tick(4);
        chk("R4 data high, sclk high", {31'd0, tx_bit}, 1);
        sclk_pin = 1'b0; sdio_pin = 1'b0; tick(4);
        chk("R4 data low, sclk low", {31'd0, tx_bit}, 0);
        sdio_pin = 1'b1; tick(4);
        chk("R4 data high, sclk low", {31'd0, tx_bit}, 1);

        // R5: enable fall without hold
        en_pin = 1'b0; tick(5);
        chk("R5 enables off", {30'd0, pa_en, pll_en}, 0);
        chk("R5 data off", {31'd0, tx_bit}, 0);

        // R6 R7: hold session
        en_pin = 1'b1; sdio_pin = 1'b0;
        issue(1'b1, 1'b0, 1'b1, 2'd1);
        start_tx();
        sdio_pin = 1'b1; tick(4);
        en_pin = 1'b0; tick(5);
        chk("R6 pa stays on", {31'd0, pa_en}, 1);
        chk("R6 frozen data", {31'd0, tx_bit}, 1);
        sdio_pin = 1'b0; tick(5);
        chk("R6 later data ignored", {31'd0, tx_bit}, 1);
        tick(HOLD - 20);
        chk("R7 still on before timeout", {30'd0, pa_en, pll_en}, 3);
        tick(30);
        chk("R7 off after timeout", {30'd0, pa_en, pll_en}, 0);

        // R8: command during hold
        en_pin = 1'b1;
        issue(1'b1, 1'b0, 1'b0, 2'd3);
        start_tx();
        en_pin = 1'b0; tick(15);
        issue(1'b1, 1'b0, 1'b0, 2'd3);
        chk("R8 pa dropped, pll kept", {30'd0, pa_en, pll_en}, 1);
        en_pin = 1'b1;
        start_tx();
        chk("R8 restarted session active", {31'd0, pa_en}, 1);
        en_pin = 1'b0; tick(HOLD - 10);
        chk("R8 fresh hold timer", {31'd0, pa_en}, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule